// File: doc/BRIEF.md
# Sequential Unsigned Integer Divider

This block divides one unsigned integer by another over several clock cycles, resolving one quotient bit per cycle with a restoring shift-and-subtract loop. A single-cycle pulse on the start input latches both operands. The block then runs for a fixed number of iterations equal to the operand width. It raises a completion flag and holds the quotient and remainder until the next start.

The operand width is a parameter, and the same source serves narrow and wide instances (4-bit and 32-bit builds are both intended). Signed operands are not supported. A zero divisor yields a fixed, documented pattern rather than an error. Upstream logic simply pulses start with fresh operands whenever it wants a new result and waits for done.

Top module: `divu_seq`

## Requirements
- R1: While reset is asserted and after its release with no start, done is 0 and both quotient and remainder read 0.
- R2: Operands are sampled only at a clock edge where start is 1; dividend and divisor input changes at any other time do not alter the result or the held outputs.
- R3: With the capture edge counted as edge 0, done stays 0 through edges 1 to WIDTH-1 and reads 1 after edge WIDTH, one quotient bit being resolved at each of edges 1 to WIDTH.
- R4: For a nonzero divisor, while done is 1 the quotient equals floor(dividend / divisor) and the remainder equals dividend mod divisor, for the operands captured at the last start.
- R5: While done is 1 and start is 0, done stays 1 and quotient and remainder do not change.
- R6: A start sampled while done is 1 clears done at that same edge and begins a new division with the new operands.
- R7: A start sampled while a division is in progress abandons it; the operands and the latency of R3 are then taken from this latest start.
- R8: With a zero divisor, the finished result is a quotient of all ones (2^WIDTH - 1) and a remainder equal to the captured dividend.
- R9: The same behaviour holds at WIDTH = 4 and WIDTH = 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture operands and begin a division at this edge |
| dividend | input | WIDTH | Unsigned dividend, sampled when start is 1 |
| divisor | input | WIDTH | Unsigned divisor, sampled when start is 1 |
| quotient | output | WIDTH | Quotient, valid while done is 1 |
| remainder | output | WIDTH | Remainder, valid while done is 1 |
| done | output | 1 | Result valid flag |

## Verification
Every result is due a fixed distance after the capture edge: done must be low at the first sample after capture and must read high at the sample that follows edge WIDTH. The bench drives start on a falling edge and samples on each later falling edge. It confirms done is low at every sample up to edge WIDTH, then checks done, quotient and remainder exactly at the sample after edge WIDTH, and checks the hold one cycle later while the operand inputs are scrambled. Restarts are issued a few cycles into a run, and the latency count restarts from that second capture edge. The checker counts edges since the last capture, so the due edge is checked without a long history window.

// File: rtl/divu_pkg.sv
package divu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/divu_ctrl.sv
module divu_ctrl
  import divu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_evt,
  output logic step_evt,
  output logic last_evt,
  output logic done
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // start always wins: a capture abandons any run in progress
  assign load_evt = start;
  assign step_evt = (state_q == ST_RUN) && !start;
  assign last_evt = step_evt && (cnt_q == CNT_W'(1));
  assign done     = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (load_evt) begin
      state_d = ST_RUN;
      cnt_d   = CNT_W'(WIDTH);
    end else if (step_evt) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (last_evt) state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/divu_datapath.sv
module divu_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic             step_evt,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int PAIR_W = 2 * WIDTH;

  logic [WIDTH-1:0]  rem_q, quo_q, dvs_q;
  logic [PAIR_W-1:0] next_pair;

  // One restoring iteration: shift {rem,quo} left, trial-subtract divisor
  // from the widened partial remainder, keep or restore by the sign bit.
  function automatic logic [PAIR_W-1:0] restore_step(
    input logic [WIDTH-1:0] rem,
    input logic [WIDTH-1:0] quo,
    input logic [WIDTH-1:0] dvs
  );
    logic [WIDTH:0]   part;
    logic [WIDTH:0]   diff;
    logic [WIDTH-1:0] quo_sh;
    part   = {rem, quo[WIDTH-1]};
    diff   = part - {1'b0, dvs};
    quo_sh = quo << 1;
    if (!diff[WIDTH]) restore_step = {diff[WIDTH-1:0], quo_sh | WIDTH'(1)};
    else              restore_step = {part[WIDTH-1:0], quo_sh};
  endfunction

  assign next_pair = restore_step(rem_q, quo_q, dvs_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_evt) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step_evt) begin
      {rem_q, quo_q} <= next_pair;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/divu_seq.sv
module divu_seq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             done
);
  // Named internal events, observed by the bound checker
  logic load_evt;
  logic step_evt;
  logic last_evt;

  divu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .last_evt (last_evt),
    .done     (done)
  );

  divu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .step_evt  (step_evt),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );
endmodule

// File: rtl/divu_seq_chk.sv
module divu_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             done,
  input logic             load_evt,
  input logic             step_evt,
  input logic             last_evt
);
  localparam int LIM   = WIDTH + 1;
  localparam int SCE_W = $clog2(LIM + 1);

  logic [WIDTH-1:0]   ref_dvd, ref_dvs;
  logic [SCE_W-1:0]   since_cap;
  logic [2*WIDTH-1:0] recombined;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_dvd   <= '0;
      ref_dvs   <= '0;
      since_cap <= SCE_W'(LIM);
    end else if (start) begin
      ref_dvd   <= dividend;
      ref_dvs   <= divisor;
      since_cap <= '0;
    end else if (since_cap < SCE_W'(LIM)) begin
      since_cap <= since_cap + SCE_W'(1);
    end
  end

  assign recombined = ({{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, ref_dvs})
                    + {{WIDTH{1'b0}}, remainder};

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> since_cap == SCE_W'(WIDTH));

  assert_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    since_cap == SCE_W'(WIDTH) |-> done);

  assert_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && ref_dvs != '0 |->
      recombined == {{WIDTH{1'b0}}, ref_dvd} && remainder < ref_dvs);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(quotient) && $stable(remainder));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  assert_events_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, step_evt}));

  assert_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> done);

  assert_divzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && ref_dvs == '0 |-> quotient == '1 && remainder == ref_dvd);
endmodule

bind divu_seq divu_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .quotient  (quotient),
  .remainder (remainder),
  .done      (done),
  .load_evt  (load_evt),
  .step_evt  (step_evt),
  .last_evt  (last_evt)
);

// File: tb/divu_seq_tb.sv
module divu_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic        st32 = 1'b0, st4 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0, q32, r32;
  logic [3:0]  a4 = '0, b4 = '0, q4, r4;
  logic        d32, d4;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  divu_seq #(.WIDTH(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(st32), .dividend(a32), .divisor(b32),
    .quotient(q32), .remainder(r32), .done(d32)
  );

  divu_seq #(.WIDTH(4)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .start(st4), .dividend(a4), .divisor(b4),
    .quotient(q4), .remainder(r4), .done(d4)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: long division by the language operators, zero divisor by rule
  function automatic logic [31:0] ref_q(input logic [31:0] a, b, input int w);
    logic [31:0] all1 = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (b == 0) ? all1 : a / b;
  endfunction

  function automatic logic [31:0] ref_r(input logic [31:0] a, b);
    return (b == 0) ? a : a % b;
  endfunction

  function automatic logic [31:0] mask_w(input logic [31:0] v, input int w);
    return (w == 32) ? v : (v & ((32'd1 << w) - 32'd1));
  endfunction

  task automatic drive(input bit narrow, input logic s, input logic [31:0] a, b);
    if (narrow) begin st4 = s; a4 = a[3:0]; b4 = b[3:0]; end
    else        begin st32 = s; a32 = a; b32 = b; end
  endtask

  function automatic logic get_done(input bit narrow);
    return narrow ? d4 : d32;
  endfunction

  function automatic logic [31:0] get_q(input bit narrow);
    return narrow ? {28'd0, q4} : q32;
  endfunction

  function automatic logic [31:0] get_r(input bit narrow);
    return narrow ? {28'd0, r4} : r32;
  endfunction

  // Start at a falling edge; capture is the next rising edge (edge 0).
  // Sample k after capture is taken at the falling edge after edge k-1.
  task automatic run(input bit narrow, input logic [31:0] a_in, b_in, input bit abort);
    int          w = narrow ? 4 : 32;
    logic [31:0] a = mask_w(a_in, w);
    logic [31:0] b = mask_w(b_in, w);
    bit          early_ok = 1'b1;
    logic [31:0] hq, hr;
    if (abort) begin
      @(negedge clk); drive(narrow, 1'b1, $urandom, $urandom);
      @(negedge clk); drive(narrow, 1'b0, $urandom, $urandom);
      @(negedge clk);
    end
    @(negedge clk); drive(narrow, 1'b1, a, b);
    @(negedge clk); drive(narrow, 1'b0, $urandom, $urandom);
    // R6 / R7: capture clears done whatever the block was doing
    chk(get_done(narrow) == 1'b0, abort ? "R7" : "R6", "done after capture",
        get_done(narrow), 0);
    for (int k = 2; k <= w; k++) begin
      @(negedge clk);
      if (get_done(narrow)) early_ok = 1'b0;
    end
    chk(early_ok, "R3", "done early", !early_ok, 0);
    @(negedge clk);
    chk(get_done(narrow) == 1'b1, "R3", "done at edge WIDTH", get_done(narrow), 1);
    chk(get_q(narrow) == ref_q(a, b, w), (b == 0) ? "R8" : "R4", "quotient",
        get_q(narrow), ref_q(a, b, w));
    chk(get_r(narrow) == ref_r(a, b), (b == 0) ? "R8" : "R4", "remainder",
        get_r(narrow), ref_r(a, b));
    hq = get_q(narrow);
    hr = get_r(narrow);
    drive(narrow, 1'b0, ~a, ~b);
    @(negedge clk);
    chk(get_done(narrow) && get_q(narrow) == hq && get_r(narrow) == hr,
        "R5", "hold with operand inputs changed (R2)", get_q(narrow), hq);
  endtask

  initial begin
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'h5EED_0417);
    repeat (3) @(negedge clk);
    chk(d32 == 1'b0 && q32 == 0 && r32 == 0, "R1", "reset 32-bit", q32 | r32 | d32, 0);
    chk(d4 == 1'b0 && q4 == 0 && r4 == 0, "R1", "reset 4-bit", q4 | r4 | d4, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(d32 == 1'b0 && q32 == 0 && r32 == 0, "R1", "idle after reset", q32 | r32 | d32, 0);

    // Directed corners, 32-bit (R9)
    run(1'b0, 32'd100, 32'd7, 1'b0);
    run(1'b0, 32'd0, 32'd5, 1'b0);
    run(1'b0, 32'd5, 32'd9, 1'b0);
    run(1'b0, 32'hFFFF_FFFF, 32'd1, 1'b0);
    run(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run(1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0);
    run(1'b0, 32'd123456, 32'd0, 1'b0);
    run(1'b0, 32'd1000, 32'd33, 1'b1);

    // Constrained random 32-bit: divisor widths spread by a random shift
    for (int i = 0; i < 200; i++) begin
      logic [31:0] ra = $urandom;
      logic [31:0] rb = $urandom >> ($urandom % 32);
      run(1'b0, ra, rb, (i % 17) == 5);
    end

    // Exhaustive 4-bit, including zero divisor (R8, R9)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run(1'b1, 32'(a), 32'(b), (a == 9) && (b == 4));
      end
    end

    report();
  end
endmodule